// File: doc/BRIEF.md
# Load-Store Unit With Local Register Bus Trap

This block carries out the four memory instructions of a small shader core. It forms a 16-bit dword address from either the instruction's immediate word alone or from a base register plus the sign-extended immediate. It then sends the access to one of two places. The core's private data RAM takes every address below 0xFF00. The top 256 dword addresses go to a narrow processor-local register bus, through which the core reaches its DMA engine and other accelerator units. Loads return their data, tagged with the destination register index, on a writeback port.

RAM accesses start in the cycle the request is presented, and RAM load data is handed back one cycle later. A store on the local bus is a single-cycle write strobe. A load on the local bus issues a one-cycle read strobe, then raises `busy` and waits for the bus to return data with a read-valid pulse. Requests presented while `busy` is high are not accepted. The core is expected to hold its pipeline while `busy` is high.

Top module: `lsu_bus_trap`

## Requirements
- R1: Opcode 0x40 (store to immediate address) asserts `ram_en` and `ram_we` in the request cycle, with `ram_addr` equal to `imm` and `ram_wdata` equal to `src_a`.
- R2: Opcode 0x41 (store to register-relative address) writes `src_a` to the address `base_b` + sign-extended `imm`, truncated to 16 bits. For example, 0xFFF0 + 0x0020 gives 0x0010.
- R3: Opcode 0x42 (load from immediate address) asserts `ram_en` with `ram_we` low and `ram_addr` = `imm`. In the next cycle it raises `wb_valid`, with `wb_idx` = the request's `dst_idx` and `wb_data` = `ram_rdata`. Loads issued in back-to-back cycles return in order.
- R4: Opcode 0x43 (load from register-relative address) uses `base_b` + sign-extended `imm`, truncated to 16 bits. `src_a` has no effect on the address.
- R5: An effective address in 0xFF00..0xFFFF never asserts `ram_en` or `ram_we`. A store there pulses `lb_wr` for one cycle, with `lb_addr` = address bits 7:0 and `lb_wdata` = `src_a`. At most one of `ram_en`, `lb_wr` and `lb_rd` is high in any cycle.
- R6: A load in the trapped range pulses `lb_rd` in the request cycle. `busy` is high from the next cycle through the cycle in which `lb_rvalid` is high. `wb_valid` rises only in that `lb_rvalid` cycle, with `wb_data` = `lb_rdata`. While `busy` is high, no strobe is asserted for a new request.
- R7: With `req_valid` low, or with any opcode other than 0x40..0x43, no RAM or bus strobe is asserted and no writeback follows.
- R8: After reset, and after a reset applied while a bus load is outstanding, `busy` and `wb_valid` are low.
- R9: An `lb_rvalid` pulse while no bus load is outstanding produces no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A memory instruction is presented this cycle |
| req_op | input | 7 | Instruction opcode |
| src_a | input | 32 | Store data (register A) |
| base_b | input | 16 | Low 16 bits of base register B |
| imm | input | 16 | Immediate word |
| dst_idx | input | 3 | Load destination register index |
| busy | output | 1 | Bus load outstanding; new requests are not accepted |
| ram_en | output | 1 | Data RAM access enable |
| ram_we | output | 1 | Data RAM write enable |
| ram_addr | output | 16 | Data RAM dword address |
| ram_wdata | output | 32 | Data RAM write data |
| ram_rdata | input | 32 | Data RAM read data, one cycle after the read |
| lb_wr | output | 1 | Local bus write strobe |
| lb_rd | output | 1 | Local bus read strobe |
| lb_addr | output | 8 | Local bus register address |
| lb_wdata | output | 32 | Local bus write data |
| lb_rdata | input | 32 | Local bus read data |
| lb_rvalid | input | 1 | Local bus read data valid |
| wb_valid | output | 1 | Load result valid |
| wb_idx | output | 3 | Load result register index |
| wb_data | output | 32 | Load result data |

## Verification
The hardest situation to reach is a request arriving while a bus load is still outstanding. The bench builds it by issuing a trapped load and holding `lb_rvalid` back. It then presents a RAM store during the wait and checks that no strobe appears and that the later writeback still carries the bus data and the original index. Two related situations are built from the ports in the same way: a reset applied mid-wait, and a stray `lb_rvalid` pulse while idle. Address wrap-around is reached through base and immediate pairs whose sum carries out of 16 bits, including one that lands inside the trapped window.

// File: rtl/lsu_pkg.sv
// Shared definitions for the load-store unit: opcode values, the
// writeback tracker state, and an opcode classifier.
// Assumes 7-bit opcodes; every opcode outside the four memory ones is inert.
package lsu_pkg;

    localparam int OPW = 7;

    localparam logic [OPW-1:0] OP_ST_IMM = 7'h40;
    localparam logic [OPW-1:0] OP_ST_REG = 7'h41;
    localparam logic [OPW-1:0] OP_LD_IMM = 7'h42;
    localparam logic [OPW-1:0] OP_LD_REG = 7'h43;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_RAM  = 2'd1,
        TRK_BUS  = 2'd2
    } trk_state_e;

    typedef struct packed {
        logic is_load;
        logic is_store;
        logic use_base;
    } op_class_t;

    // Maps an opcode to its access class; unknown opcodes map to all-zero.
    function automatic op_class_t classify(input logic [OPW-1:0] op);
        op_class_t c;
        c = '0;
        case (op)
            OP_ST_IMM: c.is_store = 1'b1;
            OP_ST_REG: begin c.is_store = 1'b1; c.use_base = 1'b1; end
            OP_LD_IMM: c.is_load  = 1'b1;
            OP_LD_REG: begin c.is_load  = 1'b1; c.use_base = 1'b1; end
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
// Effective-address generator.
// Decodes the opcode and forms the dword address: the immediate alone
// (taken as unsigned) or base + sign-extended immediate. The result is
// kept to AW bits, so any carry out of the top is dropped.
// Assumes the base operand is already cut to AW bits.
module lsu_addr_gen
    import lsu_pkg::*;
#(
    parameter int AW   = 16,
    parameter int IMMW = 16
) (
    input  logic [OPW-1:0]  op,
    input  logic [AW-1:0]   base,
    input  logic [IMMW-1:0] imm,
    output logic            is_load,
    output logic            is_store,
    output logic [AW-1:0]   eff_addr
);

    op_class_t       cls;
    logic [AW-1:0]   imm_abs;   // immediate used as a plain address
    logic [AW-1:0]   imm_off;   // immediate used as a signed offset

    // Picks how the immediate is resized to the address width.
    generate
        if (AW > IMMW) begin : g_widen
            assign imm_abs = {{(AW-IMMW){1'b0}}, imm};
            assign imm_off = {{(AW-IMMW){imm[IMMW-1]}}, imm};
        end else begin : g_fit
            assign imm_abs = imm[AW-1:0];
            assign imm_off = imm[AW-1:0];
        end
    endgenerate

    // Classifies the opcode and selects the address source.
    always_comb begin
        cls      = classify(op);
        is_load  = cls.is_load;
        is_store = cls.is_store;
        eff_addr = cls.use_base ? (base + imm_off) : imm_abs;
    end

endmodule

// File: rtl/lsu_steer.sv
// Access steering.
// Sends an accepted access either to the data RAM or, when every address
// bit above the local-bus field is one, to the local register bus.
// Trapped accesses never touch the RAM enables.
// Assumes go, is_load and is_store are already gated by acceptance.
module lsu_steer #(
    parameter int AW   = 16,
    parameter int LBAW = 8
) (
    input  logic            go,
    input  logic            is_load,
    input  logic            is_store,
    input  logic [AW-1:0]   eff_addr,
    output logic            ram_en,
    output logic            ram_we,
    output logic [AW-1:0]   ram_addr,
    output logic            lb_wr,
    output logic            lb_rd,
    output logic [LBAW-1:0] lb_addr
);

    logic in_trap;
    logic active;

    // Flags the top window of the address space.
    always_comb in_trap = &eff_addr[AW-1:LBAW];

    // Drives exactly one target's strobes for an accepted access.
    always_comb begin
        active   = go & (is_load | is_store);
        ram_en   = active & ~in_trap;
        ram_we   = go & is_store & ~in_trap;
        lb_wr    = go & is_store & in_trap;
        lb_rd    = go & is_load & in_trap;
        ram_addr = eff_addr;
        lb_addr  = eff_addr[LBAW-1:0];
    end

endmodule

// File: rtl/lsu_load_track.sv
// Load return tracker.
// Remembers the destination index of an outstanding load. A RAM load is
// returned the cycle after issue. A bus load holds busy until the bus
// pulses read-valid, and returns in that same cycle.
// Assumes no new access is issued while busy is high.
module lsu_load_track
    import lsu_pkg::*;
#(
    parameter int DW = 32,
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ram_go,
    input  logic          bus_go,
    input  logic [RW-1:0] dst_idx,
    input  logic [DW-1:0] ram_rdata,
    input  logic [DW-1:0] lb_rdata,
    input  logic          lb_rvalid,
    output logic          busy,
    output logic          wb_valid,
    output logic [RW-1:0] wb_idx,
    output logic [DW-1:0] wb_data
);

    trk_state_e    state_q, state_d;
    logic [RW-1:0] idx_q;

    // Next-state choice for the tracker.
    always_comb begin
        state_d = state_q;
        case (state_q)
            TRK_BUS: if (lb_rvalid) state_d = TRK_IDLE;
            default: begin
                if (bus_go)      state_d = TRK_BUS;
                else if (ram_go) state_d = TRK_RAM;
                else             state_d = TRK_IDLE;
            end
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRK_IDLE;
        else        state_q <= state_d;
    end

    // Captures the destination index of each issued load.
    always_ff @(posedge clk) begin
        if (!rst_n)                idx_q <= '0;
        else if (ram_go | bus_go)  idx_q <= dst_idx;
    end

    // Forms the writeback from whichever source is returning.
    always_comb begin
        busy     = (state_q == TRK_BUS);
        wb_valid = (state_q == TRK_RAM) | (busy & lb_rvalid);
        wb_idx   = idx_q;
        wb_data  = busy ? lb_rdata : ram_rdata;
    end

endmodule

// File: rtl/lsu_bus_trap.sv
// Load-store unit top.
// Accepts one memory instruction per cycle while not busy, forms its
// address, steers it to the data RAM or the local register bus, and
// returns load data on the writeback port.
// Assumes a RAM with one cycle of read latency and a local bus that answers
// each read strobe with exactly one read-valid pulse.
module lsu_bus_trap
    import lsu_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int IMMW = 16,
    parameter int LBAW = 8,
    parameter int RW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [OPW-1:0]  req_op,
    input  logic [DW-1:0]   src_a,
    input  logic [AW-1:0]   base_b,
    input  logic [IMMW-1:0] imm,
    input  logic [RW-1:0]   dst_idx,
    output logic            busy,
    output logic            ram_en,
    output logic            ram_we,
    output logic [AW-1:0]   ram_addr,
    output logic [DW-1:0]   ram_wdata,
    input  logic [DW-1:0]   ram_rdata,
    output logic            lb_wr,
    output logic            lb_rd,
    output logic [LBAW-1:0] lb_addr,
    output logic [DW-1:0]   lb_wdata,
    input  logic [DW-1:0]   lb_rdata,
    input  logic            lb_rvalid,
    output logic            wb_valid,
    output logic [RW-1:0]   wb_idx,
    output logic [DW-1:0]   wb_data
);

    logic          is_load;
    logic          is_store;
    logic [AW-1:0] eff_addr;
    logic          accept;
    logic          ram_go;

    lsu_addr_gen #(.AW(AW), .IMMW(IMMW)) u_addr (
        .op       (req_op),
        .base     (base_b),
        .imm      (imm),
        .is_load  (is_load),
        .is_store (is_store),
        .eff_addr (eff_addr)
    );

    // Accepts a request only when no bus load is outstanding.
    always_comb accept = req_valid & ~busy;

    lsu_steer #(.AW(AW), .LBAW(LBAW)) u_steer (
        .go       (accept),
        .is_load  (is_load),
        .is_store (is_store),
        .eff_addr (eff_addr),
        .ram_en   (ram_en),
        .ram_we   (ram_we),
        .ram_addr (ram_addr),
        .lb_wr    (lb_wr),
        .lb_rd    (lb_rd),
        .lb_addr  (lb_addr)
    );

    // Store data goes to both targets; only the strobed one uses it.
    always_comb begin
        ram_wdata = src_a;
        lb_wdata  = src_a;
        ram_go    = ram_en & ~ram_we;
    end

    lsu_load_track #(.DW(DW), .RW(RW)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .ram_go    (ram_go),
        .bus_go    (lb_rd),
        .dst_idx   (dst_idx),
        .ram_rdata (ram_rdata),
        .lb_rdata  (lb_rdata),
        .lb_rvalid (lb_rvalid),
        .busy      (busy),
        .wb_valid  (wb_valid),
        .wb_idx    (wb_idx),
        .wb_data   (wb_data)
    );

endmodule

// File: rtl/lsu_bus_trap_chk.sv
// Property checker for the load-store unit, bound to every instance.
// Checks only port-level timing relations.
module lsu_bus_trap_chk #(
    parameter int AW   = 16,
    parameter int LBAW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ram_en,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr,
    input logic          lb_wr,
    input logic          lb_rd,
    input logic          lb_rvalid,
    input logic          busy,
    input logic          wb_valid
);

    AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) ram_we |-> ram_en); // R1
    AST_RAM_LOAD_RETURNS: assert property (@(posedge clk) disable iff (!rst_n) (ram_en && !ram_we) |=> (wb_valid && !busy)); // R3
    AST_TRAP_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n) ram_en |-> !(&ram_addr[AW-1:LBAW])); // R5
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ram_en, lb_wr, lb_rd})); // R5
    AST_BUSY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) lb_rd |=> busy); // R6
    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !(ram_en || lb_wr || lb_rd)); // R6
    AST_WAIT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n) (busy && !lb_rvalid) |-> !wb_valid); // R6
    AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (busy && lb_rvalid) |=> !busy); // R6

endmodule

bind lsu_bus_trap lsu_bus_trap_chk #(.AW(AW), .LBAW(LBAW)) u_chk (.*);

// File: tb/tb_lsu_bus_trap.sv
module tb_lsu_bus_trap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [6:0]  req_op = '0;
    logic [31:0] src_a = '0;
    logic [15:0] base_b = '0;
    logic [15:0] imm = '0;
    logic [2:0]  dst_idx = '0;
    logic        busy, ram_en, ram_we, lb_wr, lb_rd, wb_valid;
    logic [15:0] ram_addr;
    logic [31:0] ram_wdata, lb_wdata, wb_data;
    logic [31:0] ram_rdata = '0;
    logic [31:0] lb_rdata = '0;
    logic        lb_rvalid = 1'b0;
    logic [7:0]  lb_addr;
    logic [2:0]  wb_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    lsu_bus_trap dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .src_a(src_a), .base_b(base_b), .imm(imm), .dst_idx(dst_idx),
        .busy(busy), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .lb_wr(lb_wr),
        .lb_rd(lb_rd), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
        .lb_rdata(lb_rdata), .lb_rvalid(lb_rvalid), .wb_valid(wb_valid),
        .wb_idx(wb_idx), .wb_data(wb_data)
    );

    // kind: 0 nothing, 1 RAM write, 2 RAM read, 3 bus write, 4 bus read
    typedef struct packed {
        logic [6:0]  op;
        logic [31:0] a;
        logic [15:0] b;
        logic [15:0] imm;
        logic [2:0]  d;
        logic [2:0]  kind;
        logic [15:0] addr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{7'h40, 32'h1111_1111, 16'h0000, 16'h0010, 3'd0, 3'd1, 16'h0010},
        '{7'h40, 32'hA5A5_0001, 16'h0000, 16'hFF05, 3'd0, 3'd3, 16'hFF05},
        '{7'h41, 32'h2222_2222, 16'h0100, 16'hFFFF, 3'd0, 3'd1, 16'h00FF},
        '{7'h41, 32'h3333_3333, 16'hFFF0, 16'h0020, 3'd0, 3'd1, 16'h0010},
        '{7'h41, 32'h4444_4444, 16'hFE00, 16'h0105, 3'd0, 3'd3, 16'hFF05},
        '{7'h42, 32'h0000_0000, 16'h0000, 16'h1234, 3'd3, 3'd2, 16'h1234},
        '{7'h42, 32'h0000_0000, 16'h0000, 16'hFFFF, 3'd5, 3'd4, 16'hFFFF},
        '{7'h43, 32'h0000_5555, 16'h2000, 16'h8000, 3'd6, 3'd2, 16'hA000},
        '{7'h43, 32'h0000_7777, 16'hFF00, 16'h0000, 3'd1, 3'd4, 16'hFF00},
        '{7'h43, 32'h0000_0000, 16'hFFF8, 16'h0010, 3'd2, 3'd2, 16'h0008},
        '{7'h03, 32'h0000_0001, 16'h0010, 16'h0010, 3'd4, 3'd0, 16'h0000},
        '{7'h44, 32'h0000_0001, 16'h0010, 16'h0010, 3'd4, 3'd0, 16'h0000}
    };

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.kind == 3'd3) return "R5";
        if (v.kind == 3'd4) return "R6";
        case (v.op)
            7'h40: return "R1";
            7'h41: return "R2";
            7'h42: return "R3";
            7'h43: return "R4";
            default: return "R7";
        endcase
    endfunction

    task automatic idle_req();
        req_valid = 1'b0; req_op = '0; src_a = '0; base_b = '0; imm = '0; dst_idx = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; lb_rvalid = 1'b0; idle_req();
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        vec_t v;
        string t;
        do_reset();

        // R8: reset state
        #1;
        chk("R8", "busy after reset", {31'd0, busy}, 32'd0);
        chk("R8", "wb_valid after reset", {31'd0, wb_valid}, 32'd0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            t = tag_of(v);
            @(negedge clk);
            req_valid = 1'b1; req_op = v.op; src_a = v.a; base_b = v.b;
            imm = v.imm; dst_idx = v.d;
            #1;
            chk(t, "ram_en", {31'd0, ram_en}, {31'd0, (v.kind == 3'd1 || v.kind == 3'd2)});
            chk(t, "ram_we", {31'd0, ram_we}, {31'd0, (v.kind == 3'd1)});
            chk(t, "lb_wr", {31'd0, lb_wr}, {31'd0, (v.kind == 3'd3)});
            chk(t, "lb_rd", {31'd0, lb_rd}, {31'd0, (v.kind == 3'd4)});
            if (v.kind == 3'd1 || v.kind == 3'd2)
                chk(t, "ram_addr", {16'd0, ram_addr}, {16'd0, v.addr});
            if (v.kind == 3'd1)
                chk(t, "ram_wdata", ram_wdata, v.a);
            if (v.kind == 3'd3 || v.kind == 3'd4)
                chk(t, "lb_addr", {24'd0, lb_addr}, {24'd0, v.addr[7:0]});
            if (v.kind == 3'd3)
                chk(t, "lb_wdata", lb_wdata, v.a);
            @(negedge clk);
            idle_req();
            ram_rdata = 32'hC0DE_0000 + i;
            #1;
            if (v.kind == 3'd2) begin
                chk(t, "wb_valid ram load", {31'd0, wb_valid}, 32'd1);
                chk(t, "wb_idx ram load", {29'd0, wb_idx}, {29'd0, v.d});
                chk(t, "wb_data ram load", wb_data, 32'hC0DE_0000 + i);
            end else if (v.kind == 3'd4) begin
                chk(t, "busy while waiting", {31'd0, busy}, 32'd1);
                chk(t, "no wb before rvalid", {31'd0, wb_valid}, 32'd0);
                @(negedge clk);
                lb_rvalid = 1'b1; lb_rdata = 32'hB0B0_0000 + i;
                #1;
                chk(t, "wb_valid bus load", {31'd0, wb_valid}, 32'd1);
                chk(t, "wb_idx bus load", {29'd0, wb_idx}, {29'd0, v.d});
                chk(t, "wb_data bus load", wb_data, 32'hB0B0_0000 + i);
                @(negedge clk);
                lb_rvalid = 1'b0;
                #1;
                chk(t, "busy released", {31'd0, busy}, 32'd0);
            end else begin
                chk(t, "no wb", {31'd0, wb_valid}, 32'd0);
                chk(t, "not busy", {31'd0, busy}, 32'd0);
            end
        end

        // R7: store opcode with req_valid low does nothing
        @(negedge clk);
        req_valid = 1'b0; req_op = 7'h40; imm = 16'h0010; src_a = 32'h9;
        #1;
        chk("R7", "ram_en with req_valid low", {31'd0, ram_en}, 32'd0);
        chk("R7", "lb_wr with req_valid low", {31'd0, lb_wr}, 32'd0);
        @(negedge clk); idle_req(); #1;
        chk("R7", "no wb after invalid", {31'd0, wb_valid}, 32'd0);

        // R6: request during outstanding bus load is not accepted
        @(negedge clk);
        req_valid = 1'b1; req_op = 7'h42; imm = 16'hFF20; dst_idx = 3'd7;
        @(negedge clk);
        req_op = 7'h40; imm = 16'h0040; src_a = 32'hDEAD_0001;
        #1;
        chk("R6", "ram_en blocked while busy", {31'd0, ram_en}, 32'd0);
        chk("R6", "ram_we blocked while busy", {31'd0, ram_we}, 32'd0);
        @(negedge clk);
        idle_req(); lb_rvalid = 1'b1; lb_rdata = 32'h5151_5151;
        #1;
        chk("R6", "wb_idx after blocked req", {29'd0, wb_idx}, 32'd7);
        chk("R6", "wb_data after blocked req", wb_data, 32'h5151_5151);
        @(negedge clk); lb_rvalid = 1'b0; #1;
        chk("R6", "no wb after release", {31'd0, wb_valid}, 32'd0);

        // R9: stray read-valid while idle
        @(negedge clk); lb_rvalid = 1'b1; lb_rdata = 32'h0BAD_0BAD; #1;
        chk("R9", "stray rvalid no wb", {31'd0, wb_valid}, 32'd0);
        @(negedge clk); lb_rvalid = 1'b0; #1;
        chk("R9", "stray rvalid no busy", {31'd0, busy}, 32'd0);

        // R3: back-to-back RAM loads return in order
        @(negedge clk);
        req_valid = 1'b1; req_op = 7'h42; imm = 16'h0100; dst_idx = 3'd1;
        @(negedge clk);
        imm = 16'h0101; dst_idx = 3'd2; ram_rdata = 32'h0000_0A01;
        #1;
        chk("R3", "first of pair idx", {29'd0, wb_idx}, 32'd1);
        chk("R3", "first of pair valid", {31'd0, wb_valid}, 32'd1);
        @(negedge clk);
        idle_req(); ram_rdata = 32'h0000_0A02;
        #1;
        chk("R3", "second of pair idx", {29'd0, wb_idx}, 32'd2);
        chk("R3", "second of pair data", wb_data, 32'h0000_0A02);

        // R8: reset while a bus load is outstanding
        @(negedge clk);
        req_valid = 1'b1; req_op = 7'h43; base_b = 16'hFF10; imm = 16'h0000; dst_idx = 3'd4;
        @(negedge clk); idle_req(); #1;
        chk("R8", "busy before mid-wait reset", {31'd0, busy}, 32'd1);
        do_reset();
        #1;
        chk("R8", "busy after mid-wait reset", {31'd0, busy}, 32'd0);
        chk("R8", "wb_valid after mid-wait reset", {31'd0, wb_valid}, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule